// File: doc/BRIEF.md
# Iterative Radix-8 Booth Multiplier

A sequential integer multiplier for two W-bit operands (W = 32 by default). It returns a 2W-bit product and handles both two's-complement and unsigned operands. The multiplier operand is recoded three bits at a time into signed digits in the range -4..+4. Each cycle, one selected multiple of the multiplicand is added into an accumulator, and the accumulator then shifts right by three. The odd multiple 3Y cannot be made by wiring, so one adder pass forms it before the loop starts. The even multiples 2Y and 4Y are plain left shifts.

The caller presents operands and a mode bit together with `valid_i`. They are taken on a clock edge where `ready_o` is also high. `ready_o` then stays low while the block works. When the result is ready, `done_o` pulses for one cycle and `product_o` carries the product. The product stays on `product_o` until the next operation is accepted. With W = 32 there are eleven digit steps plus one precompute cycle, so each multiply takes twelve cycles.

Top module: `booth8_mul`

## Requirements
- R1: An operation is accepted on a rising edge where `valid_i` and `ready_o` are both high. `ready_o` is low from the cycle after acceptance until the cycle in which `done_o` is high.
- R2: While `ready_o` is low, `valid_i`, `a_i`, `b_i` and `signed_i` have no effect, and the product reported is that of the accepted operands.
- R3: `done_o` is first high in the cycle that follows the (N+1)th rising edge after the accepting edge, where N = ceil((W+1)/3). For W = 32 this is 12 edges.
- R4: With `signed_i` = 0, `product_o` equals the exact unsigned product of `a_i` and `b_i`, as 2W bits.
- R5: With `signed_i` = 1, `product_o` equals the exact two's-complement product, as 2W bits.
- R6: `done_o` is high for exactly one cycle. `ready_o` is high whenever `done_o` is high. `product_o` does not change while the block is idle and no operation is being accepted.
- R7: A long carry chain on the last add gives an exact result. 0xA0 x 0x0F gives 0x960, and 0xFFFFFFFF x 0xFFFFFFFF unsigned gives 0xFFFFFFFE00000001.
- R8: In signed mode, 0x80000000 x 0x80000000 gives 0x4000000000000000, and 0xFFFFFFFF x 0x80000000 gives 0x0000000080000000.
- R9: After reset, `ready_o` = 1, `done_o` = 0 and `product_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present |
| ready_o | output | 1 | Idle, can accept |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier (recoded operand) |
| done_o | output | 1 | One-cycle result strobe |
| product_o | output | 2W | Product |

## Verification
The result is due a fixed number of edges after the accepting edge: twelve for W = 32 and four for the exhaustive W = 6 instance. The bench counts rising edges from acceptance and samples `done_o` and `product_o` on each falling edge. It flags any result that arrives at a different count. During the busy window it drives `valid_i` high with unrelated operands, and it checks that the result that arrives belongs to the accepted pair. `ready_o` is sampled at the falling edge before acceptance and at the one after it.

// File: rtl/booth8_pkg.sv
package booth8_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ITER} st_e;

  typedef struct packed {
    logic       neg;
    logic [2:0] mag;
  } digit_t;
endpackage

// File: rtl/booth8_recode.sv
module booth8_recode
  import booth8_pkg::*;
(
  input  logic [3:0] grp_i,  // {b[i+2], b[i+1], b[i], b[i-1]}
  output digit_t     dig_o
);
  logic [2:0] t;

  // negative groups mirror positive ones under bitwise inversion
  always_comb begin
    t = grp_i[3] ? ~grp_i[2:0] : grp_i[2:0];
    dig_o.neg = grp_i[3] & ~(&grp_i[2:0]);
    dig_o.mag = {1'b0, t[2], 1'b0} + {2'b00, t[1]} + {2'b00, t[0]};
  end
endmodule

// File: rtl/booth8_sel.sv
module booth8_sel
  import booth8_pkg::*;
#(
  parameter int PW = 36
) (
  input  logic [PW-1:0] y1_i,
  input  logic [PW-1:0] y3_i,
  input  digit_t        dig_i,
  output logic [PW-1:0] pp_o,
  output logic          cin_o
);
  logic [PW-1:0] m;

  always_comb begin
    unique case (dig_i.mag)
      3'd1:    m = y1_i;
      3'd2:    m = {y1_i[PW-2:0], 1'b0};
      3'd3:    m = y3_i;
      3'd4:    m = {y1_i[PW-3:0], 2'b00};
      default: m = '0;
    endcase
    pp_o  = dig_i.neg ? ~m : m;
    cin_o = dig_i.neg;
  end
endmodule

// File: rtl/booth8_ctrl.sv
module booth8_ctrl
  import booth8_pkg::*;
#(
  parameter int N = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o,
  output logic load_o,
  output logic pre_o,
  output logic step_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign ready_o = (st_q == ST_IDLE);
  assign load_o  = ready_o & valid_i;
  assign pre_o   = (st_q == ST_PRE);
  assign step_o  = (st_q == ST_ITER);
  assign last    = (cnt_q == CW'(N - 1));
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (valid_i) st_q <= ST_PRE;
        ST_PRE: begin
          st_q  <= ST_ITER;
          cnt_q <= '0;
        end
        ST_ITER: begin
          if (last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/booth8_mul.sv
module booth8_mul
  import booth8_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  output logic           ready_o,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  localparam int N   = (W + 3) / 3;  // ceil((W+1)/3) digits
  localparam int XW  = 3 * N;        // extended multiplier width
  localparam int PW  = W + 4;        // holds +-4Y and the running sum
  localparam int PRW = 2 * W;

  logic          load, pre, step;
  logic [PW-1:0] y1_q, y3_q, acc_q, pp, sum;
  logic [XW-1:0] mr_q;
  logic          prev_q, cin;
  logic          sa, sb;
  digit_t        dig;

  booth8_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .ready_o(ready_o),
    .load_o (load),
    .pre_o  (pre),
    .step_o (step),
    .done_o (done_o)
  );

  booth8_recode u_rec (
    .grp_i({mr_q[2:0], prev_q}),
    .dig_o(dig)
  );

  booth8_sel #(.PW(PW)) u_sel (
    .y1_i (y1_q),
    .y3_i (y3_q),
    .dig_i(dig),
    .pp_o (pp),
    .cin_o(cin)
  );

  assign sa  = signed_i & a_i[W-1];
  assign sb  = signed_i & b_i[W-1];
  assign sum = acc_q + pp + PW'(cin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q   <= '0;
      y3_q   <= '0;
      acc_q  <= '0;
      mr_q   <= '0;
      prev_q <= 1'b0;
    end else if (load) begin
      y1_q   <= {{(PW-W){sa}}, a_i};
      mr_q   <= {{(XW-W){sb}}, b_i};
      acc_q  <= '0;
      prev_q <= 1'b0;
    end else if (pre) begin
      y3_q <= y1_q + {y1_q[PW-2:0], 1'b0};
    end else if (step) begin
      // {acc,mr} shifts right arithmetically by one digit
      acc_q  <= {{3{sum[PW-1]}}, sum[PW-1:3]};
      mr_q   <= {sum[2:0], mr_q[XW-1:3]};
      prev_q <= mr_q[2];
    end
  end

  assign product_o = PRW'({acc_q, mr_q});
endmodule

// File: rtl/booth8_mul_chk.sv
module booth8_mul_chk #(
  parameter int W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           ready_o,
  input logic           signed_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);
  localparam int LAT = (W + 3) / 3 + 1;
  localparam int LW  = $clog2(LAT + 2);

  logic [LW-1:0]  lat_q;
  logic [2*W-1:0] exp_q;
  logic           acc;

  assign acc = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      exp_q <= '0;
    end else if (acc) begin
      lat_q <= '0;
      exp_q <= signed_i
             ? $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i})
             : {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    end else if (!ready_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ready_o);
  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == LW'(LAT));
  a_r5_product_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == exp_q);  // covers R4 as well
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> $stable(product_o));
endmodule

bind booth8_mul booth8_mul_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ready_o  (ready_o),
  .signed_i (signed_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .done_o   (done_o),
  .product_o(product_o)
);

// File: tb/sim_booth8_mul.sv
module sim_booth8_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // W = 32 instance
  logic        v0 = 1'b0, s0 = 1'b0, rdy0, dn0;
  logic [31:0] a0 = '0, b0 = '0;
  logic [63:0] p0;

  booth8_mul #(.W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v0), .ready_o(rdy0),
    .signed_i(s0), .a_i(a0), .b_i(b0), .done_o(dn0), .product_o(p0)
  );

  // W = 6 instance, exhaustive
  logic        v1 = 1'b0, s1 = 1'b0, rdy1, dn1;
  logic [5:0]  a1 = '0, b1 = '0;
  logic [11:0] p1;

  booth8_mul #(.W(6)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v1), .ready_o(rdy1),
    .signed_i(s1), .a_i(a1), .b_i(b1), .done_o(dn1), .product_o(p1)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 on W=32
  task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit s,
                       input string req);
    logic [63:0] e;
    int k;
    e = s ? 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}))
          : {32'b0, a} * {32'b0, b};
    @(negedge clk);
    chk(rdy0 === 1'b1, "R1 ready idle", {63'b0, rdy0}, 64'd1);
    v0 = 1'b1; a0 = a; b0 = b; s0 = s;
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      if (dn0 === 1'b1) break;
      if (k == 0) chk(rdy0 === 1'b0, "R1 busy", {63'b0, rdy0}, 64'd0);
      // R2: junk with valid held high while busy
      a0 = ~a; b0 = b ^ 32'h5a5a_a5a5; s0 = ~s;
      @(posedge clk);
      k++;
      if (k > 40) break;
    end
    v0 = 1'b0;
    chk(k == 12, "R3 latency", 64'(k), 64'd12);
    chk(p0 === e, req, p0, e);
    chk(rdy0 === 1'b1, "R6 ready with done", {63'b0, rdy0}, 64'd1);
    @(negedge clk);
    chk(dn0 === 1'b0, "R6 done pulse", {63'b0, dn0}, 64'd0);
    chk(p0 === e, "R6 hold", p0, e);
  endtask

  task automatic run6(input logic [5:0] a, input logic [5:0] b, input bit s);
    int ea, eb, k;
    logic [11:0] e;
    ea = (s && a[5]) ? int'(a) - 64 : int'(a);
    eb = (s && b[5]) ? int'(b) - 64 : int'(b);
    e = 12'(ea * eb);
    @(negedge clk);
    v1 = 1'b1; a1 = a; b1 = b; s1 = s;
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      if (dn1 === 1'b1) break;
      v1 = 1'b0;
      @(posedge clk);
      k++;
      if (k > 20) break;
    end
    v1 = 1'b0;
    chk(k == 4 && p1 === e, s ? "R5 sweep6" : "R4 sweep6", {52'b0, p1}, {52'b0, e});
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rdy0 === 1'b1 && dn0 === 1'b0, "R9 ready/done", {62'b0, rdy0, dn0}, 64'd2);
    chk(p0 === 64'd0, "R9 product", p0, 64'd0);
    rst_n = 1'b1;

    run32(32'h0000_00a0, 32'h0000_000f, 1'b0, "R7 carry 0xA0*0x0F");
    run32(32'h0000_000f, 32'h0000_00a0, 1'b1, "R7 carry swapped");
    run32(32'hffff_ffff, 32'hffff_ffff, 1'b0, "R7 all ones unsigned");
    run32(32'h8000_0000, 32'h8000_0000, 1'b1, "R8 min*min");
    run32(32'hffff_ffff, 32'h8000_0000, 1'b1, "R8 -1*min");
    run32(32'h8000_0000, 32'hffff_ffff, 1'b0, "R4 unsigned top bit");
    run32(32'h0, 32'hdead_beef, 1'b1, "R5 zero");
    run32(32'hffff_ffff, 32'hffff_ffff, 1'b1, "R5 -1*-1");
    run32(32'h7fff_ffff, 32'h7fff_ffff, 1'b1, "R5 max*max");
    run32(32'h5555_5555, 32'haaaa_aaaa, 1'b0, "R4 alternating");
    for (int i = 0; i < 200; i++)
      run32($urandom, $urandom, i[0], i[0] ? "R5 random" : "R4 random");

    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          run6(6'(i), 6'(j), s[0]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule